// File: doc/BRIEF.md
# Double-Buffered 16-bit Output Compare Channel

This block is one compare channel of a 16-bit timer that software programs over an 8-bit data bus. It holds a live compare register and a shadow buffer. On every clock it tests the running counter value for equality with the live compare register. An equality gives a combinational match strobe for the waveform logic and sets a sticky interrupt flag.

A 16-bit value is written in two bus cycles. The high byte first goes into a shared holding latch. A later low-byte write then commits both bytes as one value. The 4-bit waveform mode chooses where the commit goes. In the non-PWM modes the committed value goes straight into the live compare register. In the PWM modes it goes into the shadow buffer. The buffer is copied into the live register only on the counter's TOP or BOTTOM event, so a PWM period never sees a half-changed threshold. The live value is also driven out so that the counter can use it as its TOP.

Top module: `cmp_channel16`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the compare register, the buffer, the holding latch and the interrupt flag to zero. After reset, top_value is 0, irq_flag is 0, and both read bytes are 0.
- R2: wr_hi stores bus_wdata into the holding latch and changes nothing else. wr_lo commits the 16-bit value {latch, bus_wdata}. The latch keeps its contents after a commit, so it is reused by later low-byte writes.
- R3: Modes 0, 4, 12 and 13 are unbuffered. A commit writes the compare register, and top_value shows it after the next clock edge.
- R4: Every other mode is buffered. A commit writes only the buffer, and the compare register keeps its value until the selected update event.
- R5: In modes 8 and 9 the buffer is copied to the compare register on a cycle with cnt_bottom high. In the other buffered modes the copy happens on a cycle with cnt_top high. In each case the other event has no effect.
- R6: rd_hi and rd_lo hold the upper and lower byte of the buffer in buffered modes, and of the compare register in unbuffered modes. A read never involves the holding latch.
- R7: match is high in exactly the cycles where cnt equals the compare register.
- R8: irq_flag is set at the edge after a cycle with match high. It stays set until a cycle with flag_clr high and match low clears it. When match and flag_clr are high in the same cycle, the flag is set.
- R9: top_value always equals the compare register. A buffered commit made in the middle of a period does not move the match position until the next selected update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wdata | input | 8 | Bus write byte |
| wr_hi | input | 1 | High-byte write strobe (loads the latch) |
| wr_lo | input | 1 | Low-byte write strobe (commits 16 bits) |
| rd_hi | output | 8 | Upper byte of the readable register |
| rd_lo | output | 8 | Lower byte of the readable register |
| mode | input | 4 | Waveform-generation mode code |
| cnt | input | 16 | Running counter value |
| cnt_top | input | 1 | Counter TOP event |
| cnt_bottom | input | 1 | Counter BOTTOM event |
| flag_clr | input | 1 | Interrupt flag clear strobe |
| match | output | 1 | Compare match strobe |
| irq_flag | output | 1 | Sticky interrupt request flag |
| top_value | output | 16 | Live compare value, usable as counter TOP |

## Verification
The bench makes a buffered commit in the middle of a running period. It then checks that the match stays at the old threshold until the TOP event and moves only in the following period. A design that bypassed the buffer would match at the new value too early, or would miss a match within that period. It pulses the event that the current mode does not select, where a design with a wrong mode decode would copy the buffer on the wrong edge of the count. It also reuses the holding latch across commits, and raises match and flag-clear in the same cycle. A design that cleared the latch after a commit, or let the clear win, would show a wrong high byte or would lose the interrupt.

// File: rtl/cmp_channel16.sv
module cmp_channel16 #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BW-1:0]   bus_wdata,
  input  logic            wr_hi,
  input  logic            wr_lo,
  output logic [BW-1:0]   rd_hi,
  output logic [BW-1:0]   rd_lo,
  input  logic [3:0]      mode,
  input  logic [2*BW-1:0] cnt,
  input  logic            cnt_top,
  input  logic            cnt_bottom,
  input  logic            flag_clr,
  output logic            match,
  output logic            irq_flag,
  output logic [2*BW-1:0] top_value
);
  localparam int VW = 2 * BW;

  logic [BW-1:0] hold_q;
  logic [VW-1:0] cmp_q, shadow_q;
  logic          buffered, at_bottom, upd;
  logic [VW-1:0] wval;

  always_comb begin
    case (mode)
      4'd0, 4'd4, 4'd12, 4'd13: buffered = 1'b0;
      default:                  buffered = 1'b1;
    endcase
  end

  assign at_bottom = (mode == 4'd8) || (mode == 4'd9);
  assign upd       = buffered && (at_bottom ? cnt_bottom : cnt_top);
  assign wval      = {hold_q, bus_wdata};
  assign match     = (cnt == cmp_q);
  assign top_value = cmp_q;
  assign rd_hi     = buffered ? shadow_q[VW-1:BW] : cmp_q[VW-1:BW];
  assign rd_lo     = buffered ? shadow_q[BW-1:0]  : cmp_q[BW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      cmp_q    <= '0;
      shadow_q <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_hi) hold_q <= bus_wdata;
      if (wr_lo) begin
        shadow_q <= wval;
        if (!buffered) cmp_q <= wval;
      end
      if (upd) cmp_q <= shadow_q;
      if (match)         irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end
  end

  // R3: an unbuffered commit reaches the live value after one edge
  a_r3_direct_write: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !buffered) |=> top_value == $past(wval));

  // R4: a buffered channel without an update event keeps its live value
  a_r4_hold_live: assert property (@(posedge clk) disable iff (rst)
    (buffered && !upd) |=> $stable(top_value));

  // R5: the update event loads the previous buffer contents
  a_r5_event_copy: assert property (@(posedge clk) disable iff (rst)
    upd |=> top_value == $past(shadow_q));

  // R8: a match wins over a simultaneous clear
  a_r8_match_wins: assert property (@(posedge clk) disable iff (rst)
    match |=> irq_flag);

  // R8: a clear without a match drops the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !match) |=> !irq_flag);

  // R2: a high-byte write alone leaves the live value untouched
  a_r2_hi_only: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo && !upd) |=> $stable(top_value));
endmodule

// File: tb/tb_cmp_channel16.sv
module tb_cmp_channel16;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_wdata;
  logic        wr_hi, wr_lo;
  logic [7:0]  rd_hi, rd_lo;
  logic [3:0]  mode;
  logic [15:0] cnt;
  logic        cnt_top, cnt_bottom, flag_clr;
  logic        match, irq_flag;
  logic [15:0] top_value;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmp_channel16 dut (
    .clk(clk), .rst(rst), .bus_wdata(bus_wdata), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .mode(mode), .cnt(cnt), .cnt_top(cnt_top),
    .cnt_bottom(cnt_bottom), .flag_clr(flag_clr), .match(match),
    .irq_flag(irq_flag), .top_value(top_value)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr16(input logic [15:0] v);
    @(negedge clk); wr_hi = 1'b1; bus_wdata = v[15:8];
    @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; bus_wdata = v[7:0];
    @(negedge clk); wr_lo = 1'b0;
  endtask

  task automatic pulse_top;
    @(negedge clk); cnt_top = 1'b1;
    @(negedge clk); cnt_top = 1'b0;
  endtask

  task automatic pulse_bottom;
    @(negedge clk); cnt_bottom = 1'b1;
    @(negedge clk); cnt_bottom = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; wr_hi = 0; wr_lo = 0; bus_wdata = 0; mode = 0; cnt = 16'hFFFF;
    cnt_top = 0; cnt_bottom = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 top_value", top_value, 0);
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 read", {rd_hi, rd_lo}, 0);
  endtask

  task automatic t_direct;
    mode = 4'd0;
    wr16(16'h1234);
    chk("R3 mode0 top_value", top_value, 16'h1234);
    chk("R6 read unbuffered", {rd_hi, rd_lo}, 16'h1234);
    mode = 4'd4;
    wr16(16'h2345);
    chk("R3 mode4 top_value", top_value, 16'h2345);
    mode = 4'd13;
    wr16(16'h3456);
    chk("R3 mode13 top_value", top_value, 16'h3456);
  endtask

  task automatic t_latch;
    mode = 4'd0;
    @(negedge clk); wr_hi = 1'b1; bus_wdata = 8'hAB;
    @(negedge clk); wr_hi = 1'b0;
    @(negedge clk);
    chk("R2 hi only no change", top_value, 16'h3456);
    @(negedge clk); wr_lo = 1'b1; bus_wdata = 8'h01;
    @(negedge clk); wr_lo = 1'b0;
    chk("R2 commit", top_value, 16'hAB01);
    @(negedge clk); wr_lo = 1'b1; bus_wdata = 8'h02;
    @(negedge clk); wr_lo = 1'b0;
    chk("R2 latch reused", top_value, 16'hAB02);
  endtask

  task automatic t_flag;
    mode = 4'd0;
    wr16(16'h1234);
    @(negedge clk); cnt = 16'h1233; #1;
    chk("R7 no match", match, 0);
    @(negedge clk); cnt = 16'h1234; #1;
    chk("R7 match", match, 1);
    @(negedge clk); cnt = 16'h0000;
    chk("R8 flag set", irq_flag, 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", irq_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R8 cleared", irq_flag, 0);
    cnt = 16'h1234; flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; cnt = 16'h0000;
    chk("R8 match wins", irq_flag, 1);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_buf_top;
    mode = 4'd14;
    wr16(16'h00AA);
    chk("R4 live unchanged", top_value, 16'h1234);
    chk("R6 read buffer", {rd_hi, rd_lo}, 16'h00AA);
    pulse_bottom();
    chk("R5 bottom ignored in mode14", top_value, 16'h1234);
    pulse_top();
    chk("R5 top update", top_value, 16'h00AA);
  endtask

  task automatic t_buf_bottom;
    mode = 4'd8;
    wr16(16'h0055);
    pulse_top();
    chk("R5 top ignored in mode8", top_value, 16'h00AA);
    pulse_bottom();
    chk("R5 bottom update", top_value, 16'h0055);
    chk("R9 top_value", top_value, 16'h0055);
  endtask

  task automatic t_mid_period;
    int first1 = -1;
    int first2 = -1;
    mode = 4'd14;
    wr16(16'd10);
    pulse_top();
    @(negedge clk); wr_hi = 1'b1; bus_wdata = 8'h00;
    @(negedge clk); wr_hi = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        cnt = 16'(c);
        cnt_top = (c == 19);
        wr_lo = (p == 0 && c == 3);
        bus_wdata = 8'd15;
        #1;
        if (match && p == 0 && first1 < 0) first1 = c;
        if (match && p == 1 && first2 < 0) first2 = c;
      end
    end
    @(negedge clk); cnt_top = 1'b0; wr_lo = 1'b0; cnt = 16'hFFFF;
    chk("R9 match stays in period", first1, 10);
    chk("R9 match moves next period", first2, 15);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_latch();
    t_flag();
    t_buf_top();
    t_buf_bottom();
    t_mid_period();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule